// File: doc/BRIEF.md
# Instruction Cycle Sequencer with Interrupt Cycle

This block is the control sequencer of a small processor core. It runs each instruction as a fetch cycle, which reads the word at the program counter through a request/ready memory port and latches it into the instruction register, and then an execute cycle. The execute cycle lasts until an external execute stage signals completion. That completion handshake can also redirect the program counter through a jump or end an interrupt handler with a return.

After every complete instruction the sequencer enters an interrupt check. If an interrupt request is present and interrupts are enabled, it does three things. It saves the program counter and the enable flag into a one-entry shadow store, clears the enable, and loads the handler address with a one-cycle acknowledge. Otherwise it fetches the next instruction straight away. A return restores the saved program counter and enable flag, and the interrupted program continues where it stopped.

Top module: `instr_seq`

## Requirements
- R1: While `rst_n` is low the sequencer holds `pc` at RESET_VEC, `ir` at zero, `int_en` at 1, the saved context at zero, and `mem_req`, `irq_ack` and `exec_busy` low.
- R2: A fetch raises `mem_req` for exactly one cycle with `mem_addr` equal to `pc`. The sequencer then waits for `mem_ready`, and `ir` takes `mem_rdata` in the cycle `mem_ready` is seen. Neither `ir` nor `exec_busy` changes while `mem_ready` stays low.
- R3: When a fetch completes, `pc` becomes the fetched address plus one.
- R4: A completion with `jump_taken` high sets `pc` to `jump_target`, and the next fetch uses that address.
- R5: `exec_busy` stays high from the end of a fetch until the cycle in which `exec_done` is sampled high.
- R6: `irq` is sampled only after an instruction has finished. A request that is raised and dropped while `exec_busy` is high produces no `irq_ack`, and the next fetch is sequential.
- R7: If `irq` is high with `int_en` set when an instruction ends, the sequencer saves `pc` and `int_en` and clears `int_en`. It then pulses `irq_ack` for one cycle while loading `pc` from `handler_vec`, and the next fetch is at that vector.
- R8: While `int_en` is clear, `irq` is ignored and the next fetch is sequential.
- R9: A completion with `ret_int` high restores `pc` and `int_en` from the saved context. The next fetch is at the restored address. `ret_int` takes precedence over `jump_taken`.
- R10: After reset, a return with no prior interrupt restores the cleared context: the next fetch is at address 0 and `int_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mem_req | output | 1 | One-cycle instruction read request |
| mem_addr | output | AW | Instruction address (the current PC) |
| mem_ready | input | 1 | Read data valid |
| mem_rdata | input | IW | Instruction word |
| ir | output | IW | Instruction register |
| pc | output | AW | Program counter |
| exec_busy | output | 1 | Execute cycle in progress |
| exec_done | input | 1 | Execute stage finished the instruction |
| jump_taken | input | 1 | Completed instruction transfers control |
| jump_target | input | AW | Target of the transfer |
| ret_int | input | 1 | Completed instruction returns from a handler |
| irq | input | 1 | Interrupt request level |
| handler_vec | input | AW | Interrupt handler start address |
| irq_ack | output | 1 | One-cycle interrupt acknowledge |
| int_en | output | 1 | Interrupt enable status flag |

## Verification
Each result has a fixed delay from its stimulus. `ir`, the `pc` increment and `exec_busy` change one edge after `mem_ready` is seen. From `exec_done`, the next `mem_req` comes two edges later on a plain instruction, three after a return, and four when an interrupt is taken, with `irq_ack` one edge before that request. The bench drives inputs on falling edges and samples on falling edges. It waits on the observable `exec_busy` and `mem_req` edges rather than fixed delays, counts acknowledges in the window between completion and the next request, and then compares the fetch address, `int_en` and the acknowledge count with a table of hand-computed values.

// File: rtl/instr_seq_pkg.sv
package instr_seq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT_MEM, ST_EXECUTE,
    ST_INT_CHECK, ST_INT_SAVE, ST_INT_VECTOR, ST_RESTORE
  } seq_state_e;

  typedef enum logic [2:0] {
    PCS_HOLD, PCS_INC, PCS_JUMP, PCS_RESTORE, PCS_VECTOR
  } pc_sel_e;
endpackage

// File: rtl/instr_seq_fsm.sv
module instr_seq_fsm
  import instr_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    mem_ready,
  input  logic    exec_done,
  input  logic    jump_taken,
  input  logic    ret_int,
  input  logic    irq,
  input  logic    int_en,
  output logic    mem_req,
  output logic    ir_load,
  output logic    exec_busy,
  output logic    irq_ack,
  output logic    ctx_save,
  output logic    ctx_restore,
  output pc_sel_e pc_sel
);
  seq_state_e state_q, state_d;

  always_comb begin
    state_d     = state_q;
    mem_req     = 1'b0;
    ir_load     = 1'b0;
    exec_busy   = 1'b0;
    irq_ack     = 1'b0;
    ctx_save    = 1'b0;
    ctx_restore = 1'b0;
    pc_sel      = PCS_HOLD;
    case (state_q)
      ST_IDLE:     state_d = ST_FETCH;
      ST_FETCH: begin
        mem_req = 1'b1;
        state_d = ST_WAIT_MEM;
      end
      ST_WAIT_MEM: if (mem_ready) begin
        ir_load = 1'b1;
        pc_sel  = PCS_INC;
        state_d = ST_EXECUTE;
      end
      ST_EXECUTE: begin
        exec_busy = 1'b1;
        if (exec_done) begin
          if (ret_int) begin
            state_d = ST_RESTORE;
          end else begin
            if (jump_taken) pc_sel = PCS_JUMP;
            state_d = ST_INT_CHECK;
          end
        end
      end
      ST_RESTORE: begin
        pc_sel      = PCS_RESTORE;
        ctx_restore = 1'b1;
        state_d     = ST_INT_CHECK;
      end
      ST_INT_CHECK: state_d = (irq && int_en) ? ST_INT_SAVE : ST_FETCH;
      ST_INT_SAVE: begin
        ctx_save = 1'b1;
        state_d  = ST_INT_VECTOR;
      end
      ST_INT_VECTOR: begin
        pc_sel  = PCS_VECTOR;
        irq_ack = 1'b1;
        state_d = ST_FETCH;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  assert_ack_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> !irq_ack);
  assert_exec_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_busy && !exec_done) |=> exec_busy);
endmodule

// File: rtl/instr_seq_ctx.sv
module instr_seq_ctx #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctx_save,
  input  logic          ctx_restore,
  input  logic [AW-1:0] pc,
  output logic [AW-1:0] saved_pc,
  output logic          int_en
);
  logic          saved_ie;
  logic          save_en;

  assign save_en = ctx_save;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      saved_pc <= '0;
      saved_ie <= 1'b0;
    end else if (save_en) begin
      saved_pc <= pc;
      saved_ie <= int_en;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           int_en <= 1'b1;
    else if (ctx_save)    int_en <= 1'b0;
    else if (ctx_restore) int_en <= saved_ie;
  end

  assert_save_clears_ie_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_save |=> !int_en);
endmodule

// File: rtl/instr_seq_pc.sv
module instr_seq_pc
  import instr_seq_pkg::*;
#(
  parameter int          AW        = 8,
  parameter int          IW        = 16,
  parameter logic [AW-1:0] RESET_VEC = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pc_sel_e       pc_sel,
  input  logic          ir_load,
  input  logic [IW-1:0] mem_rdata,
  input  logic [AW-1:0] jump_target,
  input  logic [AW-1:0] saved_pc,
  input  logic [AW-1:0] handler_vec,
  output logic [AW-1:0] pc_q,
  output logic [IW-1:0] ir_q
);
  logic [AW-1:0] pc_d;
  logic          pc_en;

  always_comb begin
    case (pc_sel)
      PCS_INC:     pc_d = pc_q + AW'(1);
      PCS_JUMP:    pc_d = jump_target;
      PCS_RESTORE: pc_d = saved_pc;
      PCS_VECTOR:  pc_d = handler_vec;
      default:     pc_d = pc_q;
    endcase
  end

  assign pc_en = (pc_sel != PCS_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pc_q <= RESET_VEC;
    else if (pc_en) pc_q <= pc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ir_q <= '0;
    else if (ir_load) ir_q <= mem_rdata;
  end
endmodule

// File: rtl/instr_seq.sv
module instr_seq
  import instr_seq_pkg::*;
#(
  parameter int            AW        = 8,
  parameter int            IW        = 16,
  parameter logic [AW-1:0] RESET_VEC = 8'h10
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ready,
  input  logic [IW-1:0] mem_rdata,
  output logic [IW-1:0] ir,
  output logic [AW-1:0] pc,
  output logic          exec_busy,
  input  logic          exec_done,
  input  logic          jump_taken,
  input  logic [AW-1:0] jump_target,
  input  logic          ret_int,
  input  logic          irq,
  input  logic [AW-1:0] handler_vec,
  output logic          irq_ack,
  output logic          int_en
);
  pc_sel_e       pc_sel;
  logic          ir_load, ctx_save, ctx_restore;
  logic [AW-1:0] saved_pc;

  instr_seq_fsm u_fsm (
    .clk, .rst_n, .mem_ready, .exec_done, .jump_taken, .ret_int, .irq,
    .int_en, .mem_req, .ir_load, .exec_busy, .irq_ack, .ctx_save,
    .ctx_restore, .pc_sel
  );

  instr_seq_ctx #(.AW(AW)) u_ctx (
    .clk, .rst_n, .ctx_save, .ctx_restore, .pc, .saved_pc, .int_en
  );

  instr_seq_pc #(.AW(AW), .IW(IW), .RESET_VEC(RESET_VEC)) u_pc (
    .clk, .rst_n, .pc_sel, .ir_load, .mem_rdata, .jump_target, .saved_pc,
    .handler_vec, .pc_q(pc), .ir_q(ir)
  );

  assign mem_addr = pc;

  assert_vector_after_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (mem_addr == $past(handler_vec)) && mem_req);
  assert_ie_clear_on_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |-> !int_en);
  assert_pc_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(exec_busy) |-> pc == $past(mem_addr) + AW'(1));
endmodule

// File: tb/instr_seq_bench.sv
module instr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int IW = 16;
  localparam logic [AW-1:0] RVEC = 8'h10;
  localparam logic [AW-1:0] HVEC = 8'h80;

  // fields: irq, jmp, tgt, ret, exp_next, exp_ack, exp_ie
  typedef struct packed {
    logic irq; logic jmp; logic [7:0] tgt; logic ret;
    logic [7:0] nxt; logic ack; logic ie;
  } vec_t;
  localparam int NV = 9;
  localparam vec_t VT [NV] = '{
    '{1'b0, 1'b0, 8'h00, 1'b0, 8'h11, 1'b0, 1'b1},  // R3 sequential
    '{1'b0, 1'b1, 8'h40, 1'b0, 8'h40, 1'b0, 1'b1},  // R4 jump
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h80, 1'b1, 1'b0},  // R7 taken
    '{1'b1, 1'b0, 8'h00, 1'b0, 8'h81, 1'b0, 1'b0},  // R8 masked
    '{1'b0, 1'b1, 8'h90, 1'b0, 8'h90, 1'b0, 1'b0},  // R4 in handler
    '{1'b0, 1'b0, 8'h00, 1'b1, 8'h41, 1'b0, 1'b1},  // R9 return
    '{1'b1, 1'b1, 8'h20, 1'b0, 8'h80, 1'b1, 1'b0},  // R7 jump then irq
    '{1'b0, 1'b1, 8'h55, 1'b1, 8'h20, 1'b0, 1'b1},  // R9 ret beats jump
    '{1'b0, 1'b0, 8'h00, 1'b0, 8'h21, 1'b0, 1'b1}   // R3
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic mem_req, mem_ready, exec_busy, exec_done, jump_taken, ret_int, irq, irq_ack, int_en;
  logic [AW-1:0] mem_addr, pc, jump_target, handler_vec;
  logic [IW-1:0] mem_rdata, ir;
  logic ready_en;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign mem_ready = ready_en;
  assign mem_rdata = {8'hA5, mem_addr};

  instr_seq #(.AW(AW), .IW(IW), .RESET_VEC(RVEC)) u_instr_seq (
    .clk, .rst_n, .mem_req, .mem_addr, .mem_ready, .mem_rdata, .ir, .pc,
    .exec_busy, .exec_done, .jump_taken, .jump_target, .ret_int, .irq,
    .handler_vec, .irq_ack, .int_en
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wait_busy();
    while (!exec_busy) @(negedge clk);
  endtask

  task automatic finish_instr(input logic i, input logic j, input logic [7:0] t, input logic r);
    irq = i; jump_taken = j; jump_target = t; ret_int = r; exec_done = 1'b1;
    @(negedge clk);
    exec_done = 1'b0; jump_taken = 1'b0; ret_int = 1'b0;
  endtask

  task automatic wait_fetch(output int acks);
    acks = 0;
    while (!mem_req) begin
      @(negedge clk);
      if (irq_ack) acks++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int acks;
    logic [7:0] cur;
    ready_en = 1'b0; exec_done = 1'b0; jump_taken = 1'b0; ret_int = 1'b0;
    irq = 1'b0; jump_target = '0; handler_vec = HVEC;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 pc", pc, RVEC); chk("R1 ir", ir, 0); chk("R1 int_en", int_en, 1);
    chk("R1 req/ack/busy", {mem_req, irq_ack, exec_busy}, 0);
    rst_n = 1'b1;
    // R2 fetch with memory stall
    while (!mem_req) @(negedge clk);
    chk("R2 fetch addr", mem_addr, RVEC);
    @(negedge clk);
    chk("R2 req one cycle", mem_req, 0);
    repeat (3) begin
      @(negedge clk);
      chk("R2 stall holds", {exec_busy, ir}, {1'b0, 16'h0});
    end
    ready_en = 1'b1;
    @(negedge clk);
    chk("R2 ir loaded", {exec_busy, ir}, {1'b1, 8'hA5, RVEC});
    chk("R3 pc inc", pc, RVEC + 1);
    cur = RVEC;
    // table walk
    for (int k = 0; k < NV; k++) begin
      wait_busy();
      chk("R2 ir word", ir, {8'hA5, cur});
      finish_instr(VT[k].irq, VT[k].jmp, VT[k].tgt, VT[k].ret);
      wait_fetch(acks);
      irq = 1'b0;
      chk("R3/R4/R7/R9 next fetch", mem_addr, VT[k].nxt);
      chk("R7/R8 ack count", acks, VT[k].ack);
      chk("R7/R9 int_en", int_en, VT[k].ie);
      cur = VT[k].nxt;
    end
    // R6 irq raised and dropped during execute
    wait_busy();
    irq = 1'b1;
    repeat (3) @(negedge clk);
    chk("R5 busy until done", exec_busy, 1);
    irq = 1'b0;
    finish_instr(1'b0, 1'b0, 8'h00, 1'b0);
    wait_fetch(acks);
    chk("R6 no ack", acks, 0);
    chk("R6 sequential", mem_addr, cur + 1);
    // R10 reset inside a handler, then return with cleared context
    wait_busy();
    finish_instr(1'b1, 1'b0, 8'h00, 1'b0);
    wait_fetch(acks);
    irq = 1'b0;
    chk("R7 vectored", mem_addr, HVEC);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1 reset pc", pc, RVEC); chk("R1 reset ie", int_en, 1);
    rst_n = 1'b1;
    wait_busy();
    finish_instr(1'b0, 1'b0, 8'h00, 1'b1);
    wait_fetch(acks);
    chk("R10 restore addr", mem_addr, 0);
    chk("R10 restore ie", int_en, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule